// File: doc/BRIEF.md
# Board System Control Register Block

This block is a small byte-wide I/O register file that sits on a simple synchronous bus inside a board controller. It answers one stand-alone control port and a window of consecutive byte ports. Writes to some of these ports change control outputs: a held processor reset request, a byte-order flag, a status lamp bit, a four-bit system control field, an address-map mode bit, and two single-cycle strobes that toggle write protection on an external non-volatile memory. Other ports return fixed identification and presence bytes.

Reads are registered. The byte a read selects appears on the read data output one clock after the read strobe and stays there until the next read. Addresses that the block does not decode read back as all ones, and writes to them change nothing. The logic that consumes the outputs (the memory, the processor reset and the address-map switch) lives outside this block.

Top module: `sysctl_regs`

## Requirements
- R1: After reset every output is 0: the reset request, the byte-order flag, the status lamp, the system control field, the map mode, both lock strobes and the read data. A read of 0x81C, 0x850 or 0x92 after reset returns 0x00.
- R2: A write to port 0x92 sets the reset request output to data bit 0 and the byte-order flag to data bit 1. Both outputs hold those levels until the next write to 0x92.
- R3: A read of port 0x92 returns the byte-order flag in bit 1 and zero in every other bit.
- R4: These reads return fixed bytes: 0x800 gives 0xEF, 0x802 gives 0xAD, 0x803 gives 0xE0, 0x80C gives 0x3C, 0x810 gives 0x39, 0x818 gives 0x00 and 0x823 gives 0x03.
- R5: Writes to 0x800, 0x802 and 0x803 change no output, and later reads of those ports still return their fixed bytes.
- R6: A write to 0x808 copies data bit 0 to the status lamp output. No other write changes the lamp.
- R7: A write to 0x81C stores data bits 3:0 in the system control field and drops bits 7:4. The field drives its output and reads back at 0x81C with bits 7:4 zero.
- R8: A write to 0x850 stores data bit 0 as the map mode. The mode drives its output from the next clock and reads back at 0x850 in bit 0, with the other bits zero.
- R9: Whatever the data value, a write to 0x810 raises lock strobe bit 0, and a write to 0x812 raises lock strobe bit 1. Each strobe is high for exactly one cycle after each such write.
- R10: A read of 0x814, of any address in 0x800..0x851 not named in R4, R7 or R8, or of any address outside that window other than 0x92, returns 0xFF.
- R11: The read data changes only in the cycle after a read strobe. Between reads it holds the last byte that was read.
- R12: A write to an address that is not decoded changes no output and no stored value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| addr_i | input | 16 | Byte port address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 8 | Registered read data |
| cpu_reset_o | output | 1 | Held processor reset request |
| le_mode_o | output | 1 | Byte-order flag (1 = little-endian) |
| status_light_o | output | 1 | Status lamp bit |
| sys_ctrl_o | output | 4 | System control field |
| map_mode_o | output | 1 | Address-map mode |
| nv_lock_o | output | 2 | Lock toggle strobes; bit 0 from 0x810, bit 1 from 0x812 |

## Verification
The bench writes data with junk in the unused upper bits to the control field and the special port. A design that kept the high nibble, or that took the reset or byte-order level from the wrong bit, would then read back or drive values that differ from the expected ones. It writes to the read-only identification ports and to undecoded addresses just inside and just outside the window, then reads back. A decoder with an off-by-one window end, or one that let these writes through, would change a control output or return a byte other than the fixed one or 0xFF. The lock strobes are sampled in the cycle after the write and again in the cycle after that, so a strobe that stays high, never rises, or rises on the wrong bit shows up. Idle cycles after a read check that the read data holds its value, so a read path that followed the address without a strobe is caught.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

   // Port decode result; the values carry no meaning outside the block
   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_SPECIAL,
      SEL_CPU_CFG,
      SEL_FEATURE,
      SEL_BASE_STAT,
      SEL_LIGHT,
      SEL_EQUIP,
      SEL_LOCK1,
      SEL_LOCK2,
      SEL_L2_INVAL,
      SEL_KEYLOCK,
      SEL_CTRL,
      SEL_L2_STAT,
      SEL_MAP
   } sel_e;

   // Offsets inside the window (software depends on these)
   localparam int OFS_CPU_CFG   = 'h00;
   localparam int OFS_FEATURE   = 'h02;
   localparam int OFS_BASE_STAT = 'h03;
   localparam int OFS_LIGHT     = 'h08;
   localparam int OFS_EQUIP     = 'h0C;
   localparam int OFS_LOCK1     = 'h10;
   localparam int OFS_LOCK2     = 'h12;
   localparam int OFS_L2_INVAL  = 'h14;
   localparam int OFS_KEYLOCK   = 'h18;
   localparam int OFS_CTRL      = 'h1C;
   localparam int OFS_L2_STAT   = 'h23;
   localparam int OFS_MAP       = 'h50;

   // Fixed identification and presence bytes
   localparam logic [7:0] VAL_CPU_CFG   = 8'hEF;
   localparam logic [7:0] VAL_FEATURE   = 8'hAD;
   localparam logic [7:0] VAL_BASE_STAT = 8'hE0;
   localparam logic [7:0] VAL_EQUIP     = 8'h3C;
   localparam logic [7:0] VAL_EXT_FEAT  = 8'h39;
   localparam logic [7:0] VAL_KEYLOCK   = 8'h00;
   localparam logic [7:0] VAL_L2_STAT   = 8'h03;

   // Decode select that drives lock strobe number idx
   function automatic sel_e lock_sel(input int idx);
      return (idx == 0) ? SEL_LOCK1 : SEL_LOCK2;
   endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
   import sysctl_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int SPECIAL_PORT = 'h0092,
   parameter int WIN_BASE     = 'h0800,
   parameter int WIN_SIZE     = 'h52
) (
   input  logic [ADDR_W-1:0] addr_i,
   output sel_e              sel_o
);

   localparam logic [ADDR_W-1:0] BASE_A    = ADDR_W'(WIN_BASE);
   localparam logic [ADDR_W-1:0] SIZE_A    = ADDR_W'(WIN_SIZE);
   localparam logic [ADDR_W-1:0] SPECIAL_A = ADDR_W'(SPECIAL_PORT);

   if (WIN_SIZE <= OFS_MAP) begin : g_bad_win
      $error("sysctl_decode: window too small for the map mode port");
   end
   if (WIN_BASE + WIN_SIZE > (1 << ADDR_W)) begin : g_bad_addr
      $error("sysctl_decode: window does not fit in the address width");
   end

   logic [ADDR_W-1:0] ofs;
   logic              in_win;

   always_comb begin
      ofs    = addr_i - BASE_A;
      in_win = (addr_i >= BASE_A) && (ofs < SIZE_A);
   end

   always_comb begin
      sel_o = SEL_NONE;
      if (addr_i == SPECIAL_A) begin
         sel_o = SEL_SPECIAL;
      end else if (in_win) begin
         case (ofs)
            ADDR_W'(OFS_CPU_CFG):   sel_o = SEL_CPU_CFG;
            ADDR_W'(OFS_FEATURE):   sel_o = SEL_FEATURE;
            ADDR_W'(OFS_BASE_STAT): sel_o = SEL_BASE_STAT;
            ADDR_W'(OFS_LIGHT):     sel_o = SEL_LIGHT;
            ADDR_W'(OFS_EQUIP):     sel_o = SEL_EQUIP;
            ADDR_W'(OFS_LOCK1):     sel_o = SEL_LOCK1;
            ADDR_W'(OFS_LOCK2):     sel_o = SEL_LOCK2;
            ADDR_W'(OFS_L2_INVAL):  sel_o = SEL_L2_INVAL;
            ADDR_W'(OFS_KEYLOCK):   sel_o = SEL_KEYLOCK;
            ADDR_W'(OFS_CTRL):      sel_o = SEL_CTRL;
            ADDR_W'(OFS_L2_STAT):   sel_o = SEL_L2_STAT;
            ADDR_W'(OFS_MAP):       sel_o = SEL_MAP;
            default:                sel_o = SEL_NONE;
         endcase
      end
   end

   // The special port must never land inside the window
   always_comb begin
      if (in_win) begin
         AST_SPECIAL_OUTSIDE: assert (addr_i != SPECIAL_A); // R10
      end
   end

endmodule

// File: rtl/sysctl_state.sv
module sysctl_state
   import sysctl_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int CTRL_W    = 4,
   parameter int NUM_LOCKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  sel_e              sel_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              cpu_reset_o,
   output logic              le_mode_o,
   output logic              status_light_o,
   output logic [CTRL_W-1:0] sys_ctrl_o,
   output logic              map_mode_o,
   output logic [NUM_LOCKS-1:0] nv_lock_o
);

   if (NUM_LOCKS != 2) begin : g_bad_locks
      $error("sysctl_state: exactly two lock strobes are decoded");
   end
   if (CTRL_W > DATA_W || CTRL_W < 1) begin : g_bad_ctrl
      $error("sysctl_state: control field must fit the data bus");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("sysctl_state: special port needs two data bits");
   end

   logic wr_special, wr_light, wr_ctrl, wr_map;

   always_comb begin
      wr_special = wr_en_i && (sel_i == SEL_SPECIAL);
      wr_light   = wr_en_i && (sel_i == SEL_LIGHT);
      wr_ctrl    = wr_en_i && (sel_i == SEL_CTRL);
      wr_map     = wr_en_i && (sel_i == SEL_MAP);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpu_reset_o    <= 1'b0;
         le_mode_o      <= 1'b0;
         status_light_o <= 1'b0;
         sys_ctrl_o     <= '0;
         map_mode_o     <= 1'b0;
      end else begin
         if (wr_special) begin
            cpu_reset_o <= wdata_i[0];
            le_mode_o   <= wdata_i[1];
         end
         if (wr_light) status_light_o <= wdata_i[0];
         if (wr_ctrl)  sys_ctrl_o     <= wdata_i[CTRL_W-1:0];
         if (wr_map)   map_mode_o     <= wdata_i[0];
      end
   end

   for (genvar gi = 0; gi < NUM_LOCKS; gi++) begin : g_lock
      always_ff @(posedge clk) begin
         if (!rst_n) nv_lock_o[gi] <= 1'b0;
         else        nv_lock_o[gi] <= wr_en_i && (sel_i == lock_sel(gi));
      end
   end

   AST_RESET_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      wr_special |=> (cpu_reset_o == $past(wdata_i[0]))); // R2
   AST_ENDIAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_special |=> $stable(le_mode_o)); // R2
   AST_LIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_light |=> $stable(status_light_o)); // R6
   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ctrl |=> $stable(sys_ctrl_o)); // R7
   AST_MAP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_map |=> (map_mode_o == $past(wdata_i[0]))); // R8
   AST_LOCK1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      nv_lock_o[0] |-> $past(wr_en_i && (sel_i == SEL_LOCK1))); // R9
   AST_LOCK2_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      nv_lock_o[1] |-> $past(wr_en_i && (sel_i == SEL_LOCK2))); // R9
   AST_LOCK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(nv_lock_o)); // R9

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
   import sysctl_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CTRL_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en_i,
   input  sel_e              sel_i,
   input  logic              le_mode_i,
   input  logic [CTRL_W-1:0] sys_ctrl_i,
   input  logic              map_mode_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam logic [DATA_W-1:0] ALL_ONES = '1;

   if (DATA_W < 8) begin : g_bad_width
      $error("sysctl_rdmux: fixed bytes need a data bus of at least 8 bits");
   end

   logic [DATA_W-1:0] rd_next;

   always_comb begin
      rd_next = ALL_ONES;
      case (sel_i)
         SEL_SPECIAL:   rd_next = DATA_W'({le_mode_i, 1'b0});
         SEL_CPU_CFG:   rd_next = DATA_W'(VAL_CPU_CFG);
         SEL_FEATURE:   rd_next = DATA_W'(VAL_FEATURE);
         SEL_BASE_STAT: rd_next = DATA_W'(VAL_BASE_STAT);
         SEL_EQUIP:     rd_next = DATA_W'(VAL_EQUIP);
         SEL_LOCK1:     rd_next = DATA_W'(VAL_EXT_FEAT);
         SEL_KEYLOCK:   rd_next = DATA_W'(VAL_KEYLOCK);
         SEL_CTRL:      rd_next = DATA_W'(sys_ctrl_i);
         SEL_L2_STAT:   rd_next = DATA_W'(VAL_L2_STAT);
         SEL_MAP:       rd_next = DATA_W'(map_mode_i);
         default:       rd_next = ALL_ONES;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       rdata_o <= '0;
      else if (rd_en_i) rdata_o <= rd_next;
   end

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en_i |=> $stable(rdata_o)); // R11
   AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && (sel_i == SEL_NONE || sel_i == SEL_L2_INVAL)) |=> (rdata_o == ALL_ONES)); // R10
   AST_SPECIAL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && sel_i == SEL_SPECIAL) |=> ($countones(rdata_o) <= 1 && rdata_o[0] == 1'b0)); // R3

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
   import sysctl_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int DATA_W       = 8,
   parameter int CTRL_W       = 4,
   parameter int NUM_LOCKS    = 2,
   parameter int SPECIAL_PORT = 'h0092,
   parameter int WIN_BASE     = 'h0800,
   parameter int WIN_SIZE     = 'h52
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr_i,
   input  logic [DATA_W-1:0]    wdata_i,
   input  logic                 wr_en_i,
   input  logic                 rd_en_i,
   output logic [DATA_W-1:0]    rdata_o,
   output logic                 cpu_reset_o,
   output logic                 le_mode_o,
   output logic                 status_light_o,
   output logic [CTRL_W-1:0]    sys_ctrl_o,
   output logic                 map_mode_o,
   output logic [NUM_LOCKS-1:0] nv_lock_o
);

   sel_e sel;

   sysctl_decode #(
      .ADDR_W       (ADDR_W),
      .SPECIAL_PORT (SPECIAL_PORT),
      .WIN_BASE     (WIN_BASE),
      .WIN_SIZE     (WIN_SIZE)
   ) i_decode (
      .addr_i (addr_i),
      .sel_o  (sel)
   );

   sysctl_state #(
      .DATA_W    (DATA_W),
      .CTRL_W    (CTRL_W),
      .NUM_LOCKS (NUM_LOCKS)
   ) i_state (
      .clk            (clk),
      .rst_n          (rst_n),
      .wr_en_i        (wr_en_i),
      .sel_i          (sel),
      .wdata_i        (wdata_i),
      .cpu_reset_o    (cpu_reset_o),
      .le_mode_o      (le_mode_o),
      .status_light_o (status_light_o),
      .sys_ctrl_o     (sys_ctrl_o),
      .map_mode_o     (map_mode_o),
      .nv_lock_o      (nv_lock_o)
   );

   sysctl_rdmux #(
      .DATA_W (DATA_W),
      .CTRL_W (CTRL_W)
   ) i_rdmux (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en_i    (rd_en_i),
      .sel_i      (sel),
      .le_mode_i  (le_mode_o),
      .sys_ctrl_i (sys_ctrl_o),
      .map_mode_i (map_mode_o),
      .rdata_o    (rdata_o)
   );

   AST_NO_RESET_GLITCH: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && addr_i == ADDR_W'(SPECIAL_PORT)) |=> $stable(cpu_reset_o)); // R12

endmodule

// File: tb/test_sysctl_regs.sv
module test_sysctl_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  rdata;
   logic        cpu_reset, le_mode, status_light, map_mode;
   logic [3:0]  sys_ctrl;
   logic [1:0]  nv_lock;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   sysctl_regs i_sysctl_regs (
      .clk            (clk),
      .rst_n          (rst_n),
      .addr_i         (addr),
      .wdata_i        (wdata),
      .wr_en_i        (wr_en),
      .rd_en_i        (rd_en),
      .rdata_o        (rdata),
      .cpu_reset_o    (cpu_reset),
      .le_mode_o      (le_mode),
      .status_light_o (status_light),
      .sys_ctrl_o     (sys_ctrl),
      .map_mode_o     (map_mode),
      .nv_lock_o      (nv_lock)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // Scoreboard: expected read bytes queued by the driver
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       rd_q = 1'b0;

   always @(posedge clk) rd_q <= rd_en;

   always @(negedge clk) begin
      if (rd_q) begin
         if (exp_q.size() == 0) begin
            check("R11 unexpected read result", 32'(rdata), 32'hx);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, 32'(rdata), 32'(e));
         end
      end
   end

   // Drivers start and end on a falling edge
   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [7:0] e, input string t);
      addr = a; rd_en = 1'b1;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check_outs(input string t, input logic rs, input logic le,
                             input logic li, input logic [3:0] sc, input logic mm);
      check({t, " reset"}, 32'(cpu_reset), 32'(rs));
      check({t, " endian"}, 32'(le_mode), 32'(le));
      check({t, " light"}, 32'(status_light), 32'(li));
      check({t, " ctrl"}, 32'(sys_ctrl), 32'(sc));
      check({t, " map"}, 32'(map_mode), 32'(mm));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check_outs("R1", 1'b0, 1'b0, 1'b0, 4'h0, 1'b0);
      check("R1 lock", 32'(nv_lock), 32'h0);
      check("R1 rdata", 32'(rdata), 32'h0);
      rd(16'h081C, 8'h00, "R1 ctrl read");
      rd(16'h0850, 8'h00, "R1 map read");
      rd(16'h0092, 8'h00, "R1 special read");

      // R4: fixed bytes
      rd(16'h0800, 8'hEF, "R4 0x800");
      rd(16'h0802, 8'hAD, "R4 0x802");
      rd(16'h0803, 8'hE0, "R4 0x803");
      rd(16'h080C, 8'h3C, "R4 0x80C");
      rd(16'h0810, 8'h39, "R4 0x810");
      rd(16'h0818, 8'h00, "R4 0x818");
      rd(16'h0823, 8'h03, "R4 0x823");

      // R11: read data holds between reads
      idle(3);
      check("R11 hold", 32'(rdata), 32'h03);

      // R10: undecoded and invalidate reads
      rd(16'h0814, 8'hFF, "R10 0x814");
      rd(16'h0808, 8'hFF, "R10 0x808");
      rd(16'h0812, 8'hFF, "R10 0x812");
      rd(16'h0801, 8'hFF, "R10 0x801");
      rd(16'h0851, 8'hFF, "R10 0x851");
      rd(16'h0852, 8'hFF, "R10 0x852");
      rd(16'h07FF, 8'hFF, "R10 0x7FF");
      rd(16'h0093, 8'hFF, "R10 0x93");

      // R2 / R3: special port
      wr(16'h0092, 8'hFD);
      check_outs("R2 bit0 only", 1'b1, 1'b0, 1'b0, 4'h0, 1'b0);
      idle(4);
      check("R2 reset held", 32'(cpu_reset), 32'h1);
      rd(16'h0092, 8'h00, "R3 endian clear");
      wr(16'h0092, 8'h03);
      check_outs("R2 both", 1'b1, 1'b1, 1'b0, 4'h0, 1'b0);
      rd(16'h0092, 8'h02, "R3 endian set");
      wr(16'h0092, 8'h02);
      check_outs("R2 endian only", 1'b0, 1'b1, 1'b0, 4'h0, 1'b0);
      rd(16'h0092, 8'h02, "R3 after reset drop");

      // R6: status lamp
      wr(16'h0808, 8'hFE);
      check("R6 even data", 32'(status_light), 32'h0);
      wr(16'h0808, 8'h01);
      check("R6 set", 32'(status_light), 32'h1);

      // R7: control field keeps only the low nibble
      wr(16'h081C, 8'hA5);
      check("R7 out", 32'(sys_ctrl), 32'h5);
      rd(16'h081C, 8'h05, "R7 read 5");
      wr(16'h081C, 8'hFA);
      check("R7 out A", 32'(sys_ctrl), 32'hA);
      rd(16'h081C, 8'h0A, "R7 read A");

      // R8: map mode
      wr(16'h0850, 8'hFF);
      check("R8 out set", 32'(map_mode), 32'h1);
      rd(16'h0850, 8'h01, "R8 read set");
      wr(16'h0850, 8'h02);
      check("R8 out clear", 32'(map_mode), 32'h0);
      rd(16'h0850, 8'h00, "R8 read clear");
      wr(16'h0850, 8'h01);

      // R9: lock strobes
      wr(16'h0810, 8'h00);
      check("R9 lock1 high", 32'(nv_lock), 32'h1);
      @(negedge clk);
      check("R9 lock1 low", 32'(nv_lock), 32'h0);
      wr(16'h0812, 8'h5A);
      check("R9 lock2 high", 32'(nv_lock), 32'h2);
      @(negedge clk);
      check("R9 lock2 low", 32'(nv_lock), 32'h0);

      // R5: read-only ports ignore writes
      wr(16'h0800, 8'h00);
      wr(16'h0802, 8'h00);
      wr(16'h0803, 8'hFF);
      check_outs("R5 outputs", 1'b0, 1'b1, 1'b1, 4'hA, 1'b1);
      check("R5 no strobe", 32'(nv_lock), 32'h0);
      rd(16'h0800, 8'hEF, "R5 0x800");
      rd(16'h0802, 8'hAD, "R5 0x802");
      rd(16'h0803, 8'hE0, "R5 0x803");

      // R12: undecoded writes
      wr(16'h0830, 8'h00);
      wr(16'h0851, 8'h00);
      wr(16'h0093, 8'hFF);
      wr(16'h081D, 8'h00);
      wr(16'h0814, 8'h00);
      check_outs("R12 outputs", 1'b0, 1'b1, 1'b1, 4'hA, 1'b1);
      check("R12 no strobe", 32'(nv_lock), 32'h0);
      rd(16'h081C, 8'h0A, "R12 ctrl kept");
      rd(16'h0092, 8'h02, "R12 endian kept");

      idle(2);
      check("R11 queue drained", 32'(exp_q.size()), 32'h0);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule